// File: doc/BRIEF.md
# Parallel-Access Shift Register with J-K Serial Entry

This block is a small register of stages (four by default) that either captures a parallel word or moves its contents one place toward the last stage, on each rising clock edge. A single mode input chooses between the two, so there is no separate hold mode. In shift mode the first stage takes its next value from a serial J-K input pair instead of a plain data bit. That pair can clear, set, hold or toggle the first stage. Tying the two serial inputs together turns the first stage into an ordinary D input.

The block drives every stage value as a true output, plus an inverted copy of the last stage. It supports serial-to-parallel and parallel-to-serial conversion and simple counting chains. A shift toward lower stages can be built outside the block by feeding each output back to the parallel input one place down and holding load mode. An active-low master reset clears every stage at once and takes priority over the clock.

Top module: `jk_shift_reg`

## Requirements
- R1: When `shift_en` is 1 at a rising clock edge, stage i+1 takes the value stage i held before the edge. The old last stage is discarded.
- R2: When `shift_en` is 0 at a rising clock edge, every stage i takes `par_d[i]`.
- R3: In shift mode, stage 0 follows the pair {`ser_j`, `ser_kn`}. 00 clears it to 0, 11 sets it to 1, 01 keeps its present value and 10 inverts it. `ser_kn` is active low.
- R4: With `ser_j` and `ser_kn` tied to the same value d, a shift loads d into stage 0.
- R5: `q_last_n` is always the inverse of the last stage `q[WIDTH-1]`.
- R6: While `rst_n` is 0, every stage reads 0 without waiting for a clock edge. Clock edges, `shift_en`, data and serial inputs have no effect during that time.
- R7: After `rst_n` returns to 1, the first rising edge performs a normal load or shift.
- R8: In shift mode `par_d` has no effect. In load mode `ser_j` and `ser_kn` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; transfers happen on the rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_en | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| ser_j | input | 1 | Serial J input for stage 0 |
| ser_kn | input | 1 | Serial K input for stage 0, active low |
| par_d | input | WIDTH | Parallel data, bit i goes to stage i |
| q | output | WIDTH | True stage values, bit i is stage i |
| q_last_n | output | 1 | Inverted value of the last stage |

## Verification
On every clock cycle, the assertions check the edge-by-edge transfer rules. This covers the stage-to-stage move and the parallel capture. It also covers the hold and toggle actions of the J-K pair, the complement output, and the cleared state while reset is low. Some behaviour shows only in multi-cycle scenarios, and the bench's scenarios cover it. These include a four-shift serial fill, a parallel-to-serial drain read from the last stage, and a run of toggles. They also include reset pulled low in the middle of a shift sequence and the clean restart on the first edge after release.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Stage-0 action, coded as {ser_j, ser_kn}
  typedef enum logic [1:0] {
    JK_CLEAR  = 2'b00,
    JK_HOLD   = 2'b01,
    JK_TOGGLE = 2'b10,
    JK_SET    = 2'b11
  } jk_op_e;

  function automatic jk_op_e jk_decode(input logic j, input logic kn);
    return jk_op_e'({j, kn});
  endfunction

  function automatic logic jk_resolve(input jk_op_e op, input logic cur);
    logic r;
    unique case (op)
      JK_CLEAR:  r = 1'b0;
      JK_SET:    r = 1'b1;
      JK_HOLD:   r = cur;
      JK_TOGGLE: r = ~cur;
      default:   r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/psr_entry.sv
module psr_entry
  import psr_pkg::*;
(
  input  logic   j,
  input  logic   kn,
  input  logic   cur,
  output jk_op_e op,
  output logic   nxt
);

  always_comb begin
    op  = jk_decode(j, kn);
    nxt = jk_resolve(op, cur);
  end

endmodule

// File: rtl/psr_stages.sv
module psr_stages #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             entry_bit,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] shift_src;
  logic [WIDTH-1:0] nxt;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign shift_src[i] = entry_bit;
      end else begin : g_rest
        assign shift_src[i] = q[i-1];
      end
      assign nxt[i] = shift_en ? shift_src[i] : par_d[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= nxt[i];
      end
    end
  endgenerate

endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg
  import psr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_j,
  input  logic             ser_kn,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);

  localparam int LAST = WIDTH - 1;

  // Named internal events for the checker
  logic   shift_fire;
  logic   load_fire;
  logic   stage0_next;
  jk_op_e entry_op;

  assign shift_fire = shift_en;
  assign load_fire  = ~shift_en;

  psr_entry u_entry (
    .j   (ser_j),
    .kn  (ser_kn),
    .cur (q[0]),
    .op  (entry_op),
    .nxt (stage0_next)
  );

  psr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_fire),
    .entry_bit (stage0_next),
    .par_d     (par_d),
    .q         (q)
  );

  assign q_last_n = ~q[LAST];

endmodule

// File: rtl/jk_shift_reg_chk.sv
module jk_shift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_fire,
  input logic             load_fire,
  input logic             ser_j,
  input logic             ser_kn,
  input logic [WIDTH-1:0] par_d,
  input logic [WIDTH-1:0] q,
  input logic             q_last_n
);

  assert_shift_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));

  assert_par_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> q == $past(par_d));

  assert_jk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && !ser_j && ser_kn) |=> $stable(q[0]));

  assert_jk_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && ser_j && !ser_kn) |=> q[0] != $past(q[0]));

  assert_tied_d_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && (ser_j == ser_kn)) |=> q[0] == $past(ser_j));

  assert_last_inv_R5: assert property (@(posedge clk)
    q_last_n != q[WIDTH-1]);

  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |-> q == '0);

endmodule

bind jk_shift_reg jk_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_fire (shift_fire),
  .load_fire  (load_fire),
  .ser_j      (ser_j),
  .ser_kn     (ser_kn),
  .par_d      (par_d),
  .q          (q),
  .q_last_n   (q_last_n)
);

// File: tb/tb_jk_shift_reg.sv
module tb_jk_shift_reg;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_en = 1'b0;
  logic         ser_j = 1'b0;
  logic         ser_kn = 1'b0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] q;
  logic         q_last_n;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;

  jk_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_j(ser_j),
    .ser_kn(ser_kn), .par_d(par_d), .q(q), .q_last_n(q_last_n)
  );

  // Vector: {shift_en, j, kn, par_d[3:0], expected q[3:0]}
  localparam logic [10:0] VEC [12] = '{
    {1'b0, 1'b0, 1'b0, 4'b1010, 4'b1010},
    {1'b1, 1'b1, 1'b1, 4'b0000, 4'b0101},
    {1'b1, 1'b0, 1'b0, 4'b1111, 4'b1010},
    {1'b1, 1'b1, 1'b0, 4'b0000, 4'b0101},
    {1'b1, 1'b1, 1'b0, 4'b0000, 4'b1010},
    {1'b1, 1'b0, 1'b1, 4'b1111, 4'b0100},
    {1'b0, 1'b1, 1'b1, 4'b0111, 4'b0111},
    {1'b1, 1'b0, 1'b1, 4'b0000, 4'b1111},
    {1'b1, 1'b0, 1'b0, 4'b0000, 4'b1110},
    {1'b0, 1'b1, 1'b0, 4'b1001, 4'b1001},
    {1'b1, 1'b1, 1'b0, 4'b0110, 4'b0010},
    {1'b1, 1'b1, 1'b1, 4'b0000, 4'b0101}
  };

  function automatic logic [W-1:0] ref_next(logic se, logic j, logic kn,
                                            logic [W-1:0] d, logic [W-1:0] cur);
    logic b0;
    if (!se) return d;
    if (j && kn)        b0 = 1'b1;
    else if (!j && !kn) b0 = 1'b0;
    else if (j)         b0 = ~cur[0];
    else                b0 = cur[0];
    return {cur[W-2:0], b0};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_inv(string req);
    n_checks++;
    if (q_last_n !== ~q[W-1]) begin
      n_fail++;
      $display("FAIL %s: q_last_n actual %b expected %b", req, q_last_n, ~q[W-1]);
    end
  endtask

  // Drive at the falling edge, clock once, sample 1 ns after the rising edge
  task automatic step(logic se, logic j, logic kn, logic [W-1:0] d);
    @(negedge clk);
    shift_en = se; ser_j = j; ser_kn = kn; par_d = d;
    model = ref_next(se, j, kn, d, model);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] drained;
    // Reset state (R6)
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset state", q, '0);
    check_inv("R5 reset complement");
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;

    // Vector table: R1 R2 R3 R8
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check($sformatf("R1/R2/R3/R8 vector %0d", i), q, VEC[i][3:0]);
      check($sformatf("R1/R2/R3 model vector %0d", i), q, model);
      check_inv("R5 complement");
    end

    // Serial fill, tied J=K as D input (R4): 1,0,1,1 -> 1011
    step(1'b0, 1'b0, 1'b0, 4'b0000);
    step(1'b1, 1'b1, 1'b1, 4'b0110);
    step(1'b1, 1'b0, 1'b0, 4'b0110);
    step(1'b1, 1'b1, 1'b1, 4'b0110);
    step(1'b1, 1'b1, 1'b1, 4'b0110);
    check("R4 serial fill", q, 4'b1011);

    // Parallel-to-serial drain read from the last stage (R1 R5)
    step(1'b0, 1'b1, 1'b0, 4'b1100);
    drained = '0;
    for (int k = 0; k < 4; k++) begin
      drained = {drained[2:0], ~q_last_n};
      step(1'b1, 1'b0, 1'b0, 4'b1111);
    end
    check("R1 drain sequence", drained, 4'b1100);
    check("R1 drain empty", q, 4'b0000);

    // Toggle run (R3): 0001, 0010, 0101, 1010
    step(1'b0, 1'b0, 1'b0, 4'b0000);
    step(1'b1, 1'b1, 1'b0, 4'b0000);
    check("R3 toggle 1", q, 4'b0001);
    step(1'b1, 1'b1, 1'b0, 4'b0000);
    step(1'b1, 1'b1, 1'b0, 4'b0000);
    step(1'b1, 1'b1, 1'b0, 4'b0000);
    check("R3 toggle run", q, 4'b1010);

    // Reset in the middle of a shift sequence (R6 R7)
    step(1'b0, 1'b0, 1'b0, 4'b1111);
    step(1'b1, 1'b0, 1'b1, 4'b0000);
    check("R1 before reset", q, 4'b1111);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 async clear", q, 4'b0000);
    shift_en = 1'b0; par_d = 4'b1111;
    repeat (3) @(posedge clk);
    #1;
    check("R6 clock ignored in reset", q, 4'b0000);
    check_inv("R5 complement in reset");
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    step(1'b0, 1'b0, 1'b0, 4'b0110);
    check("R7 first edge after reset", q, 4'b0110);
    step(1'b1, 1'b1, 1'b1, 4'b0000);
    check("R7 shift after reset", q, 4'b1101);

    finish_run();
  end

endmodule